// File: doc/BRIEF.md
# Rolling-Shutter Row Sequencer with Two-Level Select

The sequencer produces the row timing for a pixel matrix that is read one row at a time in rolling-shutter order. The 928 rows form 58 groups of 16. While a row is being read, a one-of-58 group line and a one-of-16 line for the row inside that group are held high for the whole row period. Four strobes run in a fixed order inside each period: a first correlated-double-sampling sample, a second sample, a discriminator calibrate and a discriminator latch.

A row period lasts 32 clock cycles, which is 200 ns at a 160 MHz clock. The row pointer steps through all 928 rows and then wraps to row 0. At each wrap the block gives a one-cycle frame-start pulse and increments a frame counter. A single enable input starts and stops the sequence. When enable is low, the counters are held at zero and every select and strobe stays inactive.

Every output comes from a register, or from a decode of registered state. An output therefore responds to enable one clock edge after the enable level is applied.

Top module: `row_seq_top`

## Requirements
- R1: After reset, and from the first clock edge at which enable is sampled low, every select, every strobe, the row index, the frame index and frame-start are all zero. They stay zero while enable remains low.
- R2: On the first edge that samples enable high after an idle period, the block starts at row 0, in-row cycle 0. Each later edge with enable high advances the in-row cycle, which runs 0 to 31. The row index goes up by one when cycle 31 wraps to 0.
- R3: While active, the group select is one-hot with bit number row_idx/16 set. It changes only when the row index changes.
- R4: While active, the row-in-group select is one-hot with bit number row_idx%16 set.
- R5: The first sample strobe is high on in-row cycles 2 to 9 inclusive and low on all other cycles.
- R6: The second sample strobe is high on in-row cycles 14 to 21 inclusive and low on all other cycles.
- R7: The calibrate strobe is high on in-row cycles 22 to 25 inclusive and low on all other cycles.
- R8: The latch strobe is high on in-row cycles 27 and 28 and low on all other cycles. No two strobes are high in the same cycle.
- R9: The row index wraps from 927 to 0. Frame-start is high for exactly the one cycle in which row 0 begins after such a wrap. It is not raised when the block starts from idle.
- R10: The frame index, 16 bits wide, increases by one at each wrap from row 927 to row 0.
- R11: If enable is dropped or reset is applied in the middle of a frame, the sequence restarts at row 0, cycle 0 once it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, 32 cycles per row |
| rst | input | 1 | Asynchronous active-high reset |
| en | input | 1 | Run enable; low holds the block idle and cleared |
| grp_sel | output | 58 | One-hot group select |
| row_sel | output | 16 | One-hot row-within-group select |
| cds_samp1 | output | 1 | First correlated-double-sampling strobe |
| cds_samp2 | output | 1 | Second correlated-double-sampling strobe |
| disc_cal | output | 1 | Discriminator calibrate strobe |
| disc_latch | output | 1 | Discriminator latch strobe |
| row_idx | output | 10 | Index of the row being read |
| frame_idx | output | 16 | Count of completed frames |
| frame_start | output | 1 | One-cycle pulse at the first cycle of a new frame |

## Verification
The critical coincidence is the final row boundary of a frame. On that single edge the in-row cycle wraps, the row pointer wraps, the group select moves from bit 57 back to bit 0, frame-start rises and the frame index increments. The bench runs through this edge twice. At every cycle it compares all of these outputs against an expected value queued from its own row and cycle model. A second coincidence is forced on purpose: enable is dropped on exactly the cycle-31 edge where a row advance would otherwise happen. The clear must win, which the bench judges by seeing all-zero outputs and then a clean restart at row 0.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;

    // Strobes issued inside one row period, in their order of appearance.
    typedef struct packed {
        logic samp1;
        logic samp2;
        logic cal;
        logic latch;
    } strobe_t;

    // True when pos lies inside the inclusive window [lo, hi].
    function automatic logic in_window(input int unsigned pos,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (pos >= lo) && (pos <= hi);
    endfunction

endpackage

// File: rtl/rs_onehot_dec.sv
module rs_onehot_dec #(
    parameter int N = 58,
    parameter int W = 6
) (
    input  logic [W-1:0] idx,
    input  logic         valid,
    output logic [N-1:0] onehot
);

    // One comparator per output line; valid gates the whole vector.
    for (genvar i = 0; i < N; i++) begin : g_line
        assign onehot[i] = valid && (idx == W'(i));
    end

endmodule

// File: rtl/rs_cycle_timer.sv
module rs_cycle_timer
    import row_seq_pkg::*;
#(
    parameter int CYC_PER_ROW = 32,
    parameter int S1_LO  = 2,
    parameter int S1_HI  = 9,
    parameter int S2_LO  = 14,
    parameter int S2_HI  = 21,
    parameter int CAL_LO = 22,
    parameter int CAL_HI = 25,
    parameter int LAT_LO = 27,
    parameter int LAT_HI = 28,
    localparam int CYC_W = (CYC_PER_ROW > 1) ? $clog2(CYC_PER_ROW) : 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    output logic    act_o,
    output logic    row_end_o,
    output strobe_t strobe_o
);

    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_ROW - 1);

    typedef struct packed {
        logic             act;
        logic [CYC_W-1:0] cyc;
        strobe_t          stb;
    } tstate_t;

    tstate_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = '0;
        end else if (!state_q.act) begin
            // First enabled edge: enter row 0 at cycle 0.
            state_d.act = 1'b1;
            state_d.cyc = '0;
        end else if (state_q.cyc == CYC_LAST) begin
            state_d.cyc = '0;
        end else begin
            state_d.cyc = state_q.cyc + 1'b1;
        end

        // Strobes are registered from the next cycle value so that they
        // line up with the cycle count they belong to.
        state_d.stb.samp1 = state_d.act && in_window(32'(state_d.cyc), S1_LO,  S1_HI);
        state_d.stb.samp2 = state_d.act && in_window(32'(state_d.cyc), S2_LO,  S2_HI);
        state_d.stb.cal   = state_d.act && in_window(32'(state_d.cyc), CAL_LO, CAL_HI);
        state_d.stb.latch = state_d.act && in_window(32'(state_d.cyc), LAT_LO, LAT_HI);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign act_o     = state_q.act;
    assign row_end_o = en && state_q.act && (state_q.cyc == CYC_LAST);
    assign strobe_o  = state_q.stb;

endmodule

// File: rtl/rs_row_pointer.sv
module rs_row_pointer #(
    parameter int NUM_GROUPS     = 58,
    parameter int ROWS_PER_GROUP = 16,
    parameter int FRAME_W        = 16,
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int SUB_W = (ROWS_PER_GROUP > 1) ? $clog2(ROWS_PER_GROUP) : 1,
    localparam int ROW_W = (NUM_GROUPS * ROWS_PER_GROUP > 1) ?
                           $clog2(NUM_GROUPS * ROWS_PER_GROUP) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               advance,
    output logic [GRP_W-1:0]   grp_o,
    output logic [SUB_W-1:0]   sub_o,
    output logic [ROW_W-1:0]   row_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               frame_start_o
);

    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(NUM_GROUPS - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(ROWS_PER_GROUP - 1);

    typedef struct packed {
        logic [GRP_W-1:0]   grp;
        logic [SUB_W-1:0]   sub;
        logic [ROW_W-1:0]   row;
        logic [FRAME_W-1:0] frame;
        logic               fs;
    } pstate_t;

    pstate_t ptr_d, ptr_q;
    logic    last_sub, last_grp;

    assign last_sub = (ptr_q.sub == SUB_LAST);
    assign last_grp = (ptr_q.grp == GRP_LAST);

    always_comb begin
        ptr_d    = ptr_q;
        ptr_d.fs = 1'b0;
        if (!en) begin
            ptr_d = '0;
        end else if (advance) begin
            if (last_sub) begin
                ptr_d.sub = '0;
                if (last_grp) begin
                    // End of frame: every level of the pointer wraps together.
                    ptr_d.grp   = '0;
                    ptr_d.row   = '0;
                    ptr_d.frame = ptr_q.frame + 1'b1;
                    ptr_d.fs    = 1'b1;
                end else begin
                    ptr_d.grp = ptr_q.grp + 1'b1;
                    ptr_d.row = ptr_q.row + 1'b1;
                end
            end else begin
                ptr_d.sub = ptr_q.sub + 1'b1;
                ptr_d.row = ptr_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign grp_o         = ptr_q.grp;
    assign sub_o         = ptr_q.sub;
    assign row_o         = ptr_q.row;
    assign frame_o       = ptr_q.frame;
    assign frame_start_o = ptr_q.fs;

endmodule

// File: rtl/row_seq_top.sv
module row_seq_top
    import row_seq_pkg::*;
#(
    parameter int NUM_GROUPS     = 58,
    parameter int ROWS_PER_GROUP = 16,
    parameter int CYC_PER_ROW    = 32,
    parameter int FRAME_W        = 16,
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int SUB_W = (ROWS_PER_GROUP > 1) ? $clog2(ROWS_PER_GROUP) : 1,
    localparam int ROW_W = (NUM_GROUPS * ROWS_PER_GROUP > 1) ?
                           $clog2(NUM_GROUPS * ROWS_PER_GROUP) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    output logic [NUM_GROUPS-1:0]     grp_sel,
    output logic [ROWS_PER_GROUP-1:0] row_sel,
    output logic                      cds_samp1,
    output logic                      cds_samp2,
    output logic                      disc_cal,
    output logic                      disc_latch,
    output logic [ROW_W-1:0]          row_idx,
    output logic [FRAME_W-1:0]        frame_idx,
    output logic                      frame_start
);

    logic             act;
    logic             row_end;
    strobe_t          stb;
    logic [GRP_W-1:0] grp;
    logic [SUB_W-1:0] sub;

    rs_cycle_timer #(
        .CYC_PER_ROW (CYC_PER_ROW)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .act_o     (act),
        .row_end_o (row_end),
        .strobe_o  (stb)
    );

    rs_row_pointer #(
        .NUM_GROUPS     (NUM_GROUPS),
        .ROWS_PER_GROUP (ROWS_PER_GROUP),
        .FRAME_W        (FRAME_W)
    ) u_ptr (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .advance       (row_end),
        .grp_o         (grp),
        .sub_o         (sub),
        .row_o         (row_idx),
        .frame_o       (frame_idx),
        .frame_start_o (frame_start)
    );

    rs_onehot_dec #(
        .N (NUM_GROUPS),
        .W (GRP_W)
    ) u_grp_dec (
        .idx    (grp),
        .valid  (act),
        .onehot (grp_sel)
    );

    rs_onehot_dec #(
        .N (ROWS_PER_GROUP),
        .W (SUB_W)
    ) u_sub_dec (
        .idx    (sub),
        .valid  (act),
        .onehot (row_sel)
    );

    assign cds_samp1  = stb.samp1;
    assign cds_samp2  = stb.samp2;
    assign disc_cal   = stb.cal;
    assign disc_latch = stb.latch;

endmodule

// File: rtl/row_seq_chk.sv
module row_seq_chk #(
    parameter int NUM_GROUPS     = 58,
    parameter int ROWS_PER_GROUP = 16,
    parameter int ROW_W          = 10,
    parameter int FRAME_W        = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      en,
    input logic [NUM_GROUPS-1:0]     grp_sel,
    input logic [ROWS_PER_GROUP-1:0] row_sel,
    input logic                      cds_samp1,
    input logic                      cds_samp2,
    input logic                      disc_cal,
    input logic                      disc_latch,
    input logic [ROW_W-1:0]          row_idx,
    input logic [FRAME_W-1:0]        frame_idx,
    input logic                      frame_start
);

    // R1: one edge after enable is seen low, everything is idle and cleared.
    a_r1_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (grp_sel == '0) && (row_sel == '0) &&
                       !cds_samp1 && !cds_samp2 && !disc_cal && !disc_latch &&
                       (row_idx == '0) && (frame_idx == '0) && !frame_start);

    // R2: the row index only steps by one or returns to zero.
    a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(row_idx) |-> (row_idx == '0) || (row_idx == $past(row_idx) + 1'b1));

    // R3: the group select is one-hot or idle.
    a_r3_grp_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grp_sel));

    // R3: an active group select changes only together with the row index.
    a_r3_grp_boundary: assert property (@(posedge clk) disable iff (rst)
        (grp_sel != $past(grp_sel)) && (grp_sel != '0) && ($past(grp_sel) != '0)
        |-> (row_idx != $past(row_idx)));

    // R4: the row-within-group select is one-hot, and active together with the group select.
    a_r4_row_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel) && ((row_sel == '0) == (grp_sel == '0)));

    // R8: strobes never overlap.
    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cds_samp1, cds_samp2, disc_cal, disc_latch}));

    // R8: the latch pulse is exactly two cycles long.
    a_r8_latch_two: assert property (@(posedge clk) disable iff (rst)
        $rose(disc_latch) && en |=> disc_latch);

    // R9: frame-start marks row 0 and lasts one cycle.
    a_r9_fs_row0: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (row_idx == '0));

    a_r9_fs_single: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R10: the frame index increments together with frame-start.
    a_r10_frame_inc: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (frame_idx == $past(frame_idx) + 1'b1));

endmodule

bind row_seq_top row_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .grp_sel     (grp_sel),
    .row_sel     (row_sel),
    .cds_samp1   (cds_samp1),
    .cds_samp2   (cds_samp2),
    .disc_cal    (disc_cal),
    .disc_latch  (disc_latch),
    .row_idx     (row_idx),
    .frame_idx   (frame_idx),
    .frame_start (frame_start)
);

// File: tb/row_seq_top_tb.sv
module row_seq_top_tb;

    localparam int NG     = 58;
    localparam int RPG    = 16;
    localparam int CPR    = 32;
    localparam int NROWS  = NG * RPG;
    localparam int FRAME  = NROWS * CPR;
    localparam int TAG_NORMAL  = 0;
    localparam int TAG_IDLE    = 1;
    localparam int TAG_RESTART = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;

    logic [NG-1:0]  grp_sel;
    logic [RPG-1:0] row_sel;
    logic           cds_samp1, cds_samp2, disc_cal, disc_latch;
    logic [9:0]     row_idx;
    logic [15:0]    frame_idx;
    logic           frame_start;

    always #10 clk = ~clk;

    row_seq_top u_dut (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .grp_sel     (grp_sel),
        .row_sel     (row_sel),
        .cds_samp1   (cds_samp1),
        .cds_samp2   (cds_samp2),
        .disc_cal    (disc_cal),
        .disc_latch  (disc_latch),
        .row_idx     (row_idx),
        .frame_idx   (frame_idx),
        .frame_start (frame_start)
    );

    typedef struct {
        logic [NG-1:0]  gsel;
        logic [RPG-1:0] rsel;
        logic           s1, s2, cal, lat;
        logic [9:0]     row;
        logic [15:0]    frame;
        logic           fs;
        int             tag;
    } exp_t;

    exp_t q[$];

    bit m_act;
    int m_cyc, m_row, m_frame;
    bit m_fs;
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    function automatic bit win(input int c, input int lo, input int hi);
        return (c >= lo) && (c <= hi);
    endfunction

    function automatic string tg(input int tag, input string dflt);
        if (tag == TAG_IDLE)    return "R1";
        if (tag == TAG_RESTART) return "R11";
        return dflt;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected result
    // of the following clock edge.
    task automatic step(input logic r, input logic e, input int tag);
        exp_t x;
        @(negedge clk);
        rst = r;
        en  = e;
        if (r || !e) begin
            m_act = 0; m_cyc = 0; m_row = 0; m_frame = 0; m_fs = 0;
        end else if (!m_act) begin
            m_act = 1; m_cyc = 0; m_fs = 0;
        end else begin
            m_fs = 0;
            if (m_cyc == CPR - 1) begin
                m_cyc = 0;
                if (m_row == NROWS - 1) begin
                    m_row = 0;
                    m_frame++;
                    m_fs = 1;
                end else begin
                    m_row++;
                end
            end else begin
                m_cyc++;
            end
        end
        x.gsel  = m_act ? (NG'(1) << (m_row / RPG)) : '0;
        x.rsel  = m_act ? (RPG'(1) << (m_row % RPG)) : '0;
        x.s1    = m_act && win(m_cyc, 2, 9);
        x.s2    = m_act && win(m_cyc, 14, 21);
        x.cal   = m_act && win(m_cyc, 22, 25);
        x.lat   = m_act && win(m_cyc, 27, 28);
        x.row   = 10'(m_row);
        x.frame = 16'(m_frame);
        x.fs    = m_fs;
        x.tag   = tag;
        q.push_back(x);
    endtask

    task automatic run(input int n, input logic e, input int tag);
        for (int i = 0; i < n; i++) step(1'b0, e, tag);
    endtask

    // Monitor: a quarter period after each rising edge, compare against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                chk(grp_sel == x.gsel,     tg(x.tag, "R3"), "grp_sel",     64'(grp_sel),     64'(x.gsel));
                chk(row_sel == x.rsel,     tg(x.tag, "R4"), "row_sel",     64'(row_sel),     64'(x.rsel));
                chk(cds_samp1 == x.s1,     tg(x.tag, "R5"), "cds_samp1",   64'(cds_samp1),   64'(x.s1));
                chk(cds_samp2 == x.s2,     tg(x.tag, "R6"), "cds_samp2",   64'(cds_samp2),   64'(x.s2));
                chk(disc_cal == x.cal,     tg(x.tag, "R7"), "disc_cal",    64'(disc_cal),    64'(x.cal));
                chk(disc_latch == x.lat,   tg(x.tag, "R8"), "disc_latch",  64'(disc_latch),  64'(x.lat));
                chk(row_idx == x.row,      tg(x.tag, "R2"), "row_idx",     64'(row_idx),     64'(x.row));
                chk(frame_idx == x.frame,  tg(x.tag, "R10"), "frame_idx",  64'(frame_idx),   64'(x.frame));
                chk(frame_start == x.fs,   tg(x.tag, "R9"), "frame_start", 64'(frame_start), 64'(x.fs));
            end
        end
    end

    // Watchdog: an expired timer counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=expired exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then idle with enable low.
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, TAG_IDLE);
        run(3, 1'b0, TAG_IDLE);
        // R2..R10: one full frame plus margin, crossing the 927 -> 0 wrap.
        run(FRAME + 200, 1'b1, TAG_NORMAL);
        // R1 / R11: drop enable in mid-row, then restart.
        run(5, 1'b0, TAG_IDLE);
        run(40, 1'b1, TAG_RESTART);
        // R11: drop enable exactly on the row-boundary edge.
        while (m_cyc != CPR - 1) step(1'b0, 1'b1, TAG_NORMAL);
        step(1'b0, 1'b0, TAG_IDLE);
        run(3, 1'b0, TAG_IDLE);
        // R11: reset in the middle of an active run.
        run(70, 1'b1, TAG_NORMAL);
        step(1'b1, 1'b1, TAG_IDLE);
        step(1'b1, 1'b1, TAG_IDLE);
        run(50, 1'b1, TAG_RESTART);
        // R9 / R10: two full frames, checking the frame index steps twice.
        run(2 * FRAME + 50, 1'b1, TAG_NORMAL);
        // Drain the queue.
        @(negedge clk);
        while (q.size() > 0) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule